// File: doc/BRIEF.md
# Nibble-Field Prioritized Interrupt Controller

This block collects interrupt requests from a set of sources and presents the most urgent one to the processor as a 3-bit level and a source index. Each source is configured through a 4-bit field in one of several 32-bit control words on a simple register bus. The field carries a 3-bit level, where level 0 means the source is masked, and a top "commit" bit. A field is only written when its commit bit is set, so one bus write can change a single source and leave its neighbours alone.

Sources come in two kinds. Internal sources are level sensitive: they are pending exactly while their input is high. External sources are pins. Each pin is resynchronised by a two-flop chain and watched for an edge whose direction a polarity word selects. A detected edge is held pending until software writes that source's field with the commit bit set. Such a write acknowledges the edge when it keeps the level, and also drops the edge when it masks the source. On reads the commit bit position shows the source's live pending state.

No handshake is involved. Bus writes are taken on every enabled clock, and reads are combinational from the address. The interrupt outputs are plain registered levels that the processor samples whenever it likes.

Top module: `intc_nibble_top`

## Requirements
- R1: After reset every source level is 0, every external latch is clear, irq_level and irq_src are 0, all control words read 0 except the pending bits of internal inputs that are high, and the polarity word reads 1 on every external source bit and 0 elsewhere.
- R2: Source i owns control word i/8 at bus address i/8, and occupies bits [31-4*(i%8) : 28-4*(i%8)] of it. A read returns {pending, level[2:0]} in that field.
- R3: A control-word write leaves the level and the pending latch of every field whose bit 3 (commit) is 0 unchanged.
- R4: A control-word write to a field with commit set loads that source's level from field bits [2:0]. A source at level 0 is never presented, even while pending.
- R5: An internal source is pending exactly while its src_in bit is high, and the read-back pending bit follows the input in the same cycle.
- R6: External sources are indices 0, 1, 2, 3, 25 and 26. A detected edge is latched and stays pending after the pin returns. Polarity bit i (address 4, bit i) selects a rising edge when 1 and a falling edge when 0, and an edge of the other direction is ignored.
- R7: A control-word write with commit set on an external source's field clears its latch, whether the level written is unchanged (acknowledge) or 0 (mask).
- R8: irq_level is the highest level among pending sources with a nonzero level. When levels tie, the lowest index wins. irq_src is that index. With no candidate both outputs are 0.
- R9: A change on an internal input reaches irq_level and irq_src on the first rising clock edge after it.
- R10: Polarity writes alter only external-source bits, and a write to an unmapped address (5 to 7) changes no state and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Word address: 0-3 control words, 4 polarity word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | 32 | Request inputs, one per source (pins for external sources) |
| irq_level | output | 3 | Level of the presented request, 0 when none |
| irq_src | output | 5 | Index of the presented source |

## Verification
The bench builds the block with its defaults: four control words, which give 32 sources, and the external map 0x0600000F. External fields therefore appear at the top of the first word and in the middle of the last word, next to internal ones, so a single write exercises commit-gated fields of both kinds. With 32 sources the bench can check level ties between sources in different words, the highest index (31) as winner, and rising and falling capture on separate pins. The polarity word is as wide as the bus, so the bench can also check that writes to its non-external bits have no effect.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 4;
  localparam int LVL_W    = 3;
  localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/intc_edge_unit.sv
module intc_edge_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic clr,
  output logic pend
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, pend_q, edge_det, cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur      = sync_q[SYNC_STAGES-1];
  assign edge_det = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);

  // a fresh edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (edge_det) pend_q <= 1'b1;
    else if (clr)      pend_q <= 1'b0;
  end

  assign pend = pend_q;

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_det) |=> !pend_q); // R7
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q); // R6
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int SRC_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  input  logic [NUM_SRC-1:0]       pend,
  output lvl_t                     win_lvl,
  output logic [SRC_W-1:0]         win_idx
);
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (lvl_flat[i*LVL_W +: LVL_W] > win_lvl)) begin
        win_lvl = lvl_flat[i*LVL_W +: LVL_W];
        win_idx = SRC_W'(i);
      end
    end
  end

  logic beaten;
  always_comb begin
    beaten = 1'b0;
    for (int j = 0; j < NUM_SRC; j++)
      if (pend[j] && lvl_flat[j*LVL_W +: LVL_W] > win_lvl) beaten = 1'b1;
    AST_NONE_HIGHER: assert (!beaten); // R8
    if (win_lvl != '0) begin
      AST_WIN_VALID: assert (pend[win_idx] &&
        lvl_flat[win_idx*LVL_W +: LVL_W] == win_lvl); // R8
    end
  end
endmodule

// File: rtl/intc_nibble_top.sv
module intc_nibble_top
  import intc_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter logic [NUM_WORDS*FIELDS_PER_WORD-1:0] EXT_MAP = 32'h0600_000F,
  localparam int NUM_SRC  = NUM_WORDS * FIELDS_PER_WORD,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int POL_BASE = NUM_WORDS,
  localparam int POL_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W,
  localparam int ADDR_W   = $clog2(NUM_WORDS + POL_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [LVL_W-1:0]  irq_level,
  output logic [SRC_W-1:0]  irq_src
);
  lvl_t                     lvl_q [NUM_SRC];
  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic [NUM_SRC-1:0]       pend, pol_q, commit_wr;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int WRD = i / FIELDS_PER_WORD;
    localparam int LSB = WORD_W - FIELD_W * (1 + i % FIELDS_PER_WORD);
    localparam int PW  = POL_BASE + i / WORD_W;
    localparam int PB  = i % WORD_W;

    assign commit_wr[i] = bus_we && (bus_addr == ADDR_W'(WRD)) &&
                          bus_wdata[LSB + FIELD_W - 1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            lvl_q[i] <= '0;
      else if (commit_wr[i]) lvl_q[i] <= bus_wdata[LSB +: LVL_W];
    end
    assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q[i];

    if (EXT_MAP[i]) begin : g_ext
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q[i] <= 1'b1;
        else if (bus_we && bus_addr == ADDR_W'(PW)) pol_q[i] <= bus_wdata[PB];
      end
      intc_edge_unit #(.SYNC_STAGES(2)) edge_i (
        .clk(clk), .rst_n(rst_n), .pin(src_in[i]), .rise_sel(pol_q[i]),
        .clr(commit_wr[i]), .pend(pend[i]));
    end else begin : g_int
      assign pol_q[i] = 1'b0;
      assign pend[i]  = src_in[i];
    end

    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      commit_wr[i] |=> lvl_q[i] == $past(bus_wdata[LSB +: LVL_W])); // R4
    AST_NOCOMMIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(WRD) && !bus_wdata[LSB + FIELD_W - 1])
      |=> $stable(lvl_q[i])); // R3
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (bus_addr == ADDR_W'(i / FIELDS_PER_WORD))
        bus_rdata[WORD_W - FIELD_W * (1 + i % FIELDS_PER_WORD) +: FIELD_W] =
          {pend[i], lvl_q[i]};
      if (bus_addr == ADDR_W'(POL_BASE + i / WORD_W))
        bus_rdata[i % WORD_W] = pol_q[i];
    end
  end

  lvl_t             win_lvl;
  logic [SRC_W-1:0] win_idx;

  intc_prio_arb #(.NUM_SRC(NUM_SRC)) arb_i (
    .lvl_flat(lvl_flat), .pend(pend), .win_lvl(win_lvl), .win_idx(win_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= '0;
      irq_src   <= '0;
    end else begin
      irq_level <= win_lvl;
      irq_src   <= win_idx;
    end
  end

  AST_IDLE_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) |-> (irq_src == '0)); // R8
endmodule

// File: tb/intc_nibble_top_tb_top.sv
module intc_nibble_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic [2:0]  irq_level;
  logic [4:0]  irq_src;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intc_nibble_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_level(irq_level), .irq_src(irq_src));

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] src;
    logic [2:0]  lvl;
    logic [4:0]  idx;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1, 3'd0, 32'h0000_D000, 32'h0000_0010, 3'd5, 5'd4},  // R4 src4 lvl5
    '{1'b1, 3'd1, 32'h0E00_0000, 32'h0000_0210, 3'd6, 5'd9},  // R8 higher wins
    '{1'b1, 3'd1, 32'h0800_0000, 32'h0000_0210, 3'd5, 5'd4},  // R4 mask src9
    '{1'b1, 3'd2, 32'h0000_0D00, 32'h0020_0010, 3'd5, 5'd4},  // R8 tie low idx
    '{1'b0, 3'd0, 32'h0000_0000, 32'h0020_0000, 3'd5, 5'd21}, // R5 level drop
    '{1'b1, 3'd0, 32'h0000_F000, 32'h0020_0010, 3'd7, 5'd4},  // R4 raise
    '{1'b1, 3'd0, 32'h0000_0000, 32'h0020_0010, 3'd7, 5'd4},  // R3 no commit
    '{1'b0, 3'd0, 32'h0000_0000, 32'h0000_0000, 3'd0, 5'd0},  // R8 idle
    '{1'b1, 3'd3, 32'h0000_000B, 32'h8000_0000, 3'd3, 5'd31}, // R2 last field
    '{1'b1, 3'd3, 32'h8888_8888, 32'h8000_0000, 3'd0, 5'd0}   // R4 mask all
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 level", 32'(irq_level), 32'd0);
    chk("R1 src", 32'(irq_src), 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), r);
      chk("R1 ctrl word", r, 32'h0);
    end
    rd(3'd4, r);
    chk("R1 polarity", r, 32'h0600_000F);

    foreach (VEC[k]) begin
      @(negedge clk);
      bus_we = VEC[k].we; bus_addr = VEC[k].addr; bus_wdata = VEC[k].wdata;
      src_in = VEC[k].src;
      @(negedge clk);
      bus_we = 1'b0;
      @(negedge clk);
      chk("R8 table level", 32'(irq_level), 32'(VEC[k].lvl));
      chk("R8 table src", 32'(irq_src), 32'(VEC[k].idx));
    end

    // R2 / R5 read-back layout
    src_in = '0;
    rd(3'd0, r); chk("R2 word0", r, 32'h0000_7000);
    rd(3'd2, r); chk("R2 word2", r, 32'h0000_0500);
    src_in[4] = 1'b1;
    rd(3'd0, r); chk("R5 live pending", r, 32'h0000_F000);
    src_in = '0;
    idle(2);

    // R9 one-cycle latency
    @(negedge clk);
    src_in[21] = 1'b1;
    #1 chk("R9 before edge", 32'(irq_level), 32'd0);
    @(posedge clk);
    #1 chk("R9 after edge level", 32'(irq_level), 32'd5);
    chk("R9 after edge src", 32'(irq_src), 32'd21);
    src_in = '0;
    idle(2);

    // R6 rising edge latch on source 0
    wr(3'd0, 32'hC000_0000);
    src_in[0] = 1'b1; idle(3);
    src_in[0] = 1'b0; idle(6);
    chk("R6 latched level", 32'(irq_level), 32'd4);
    chk("R6 latched src", 32'(irq_src), 32'd0);
    rd(3'd0, r); chk("R6 read pending", r, 32'hC000_7000);

    // R7 acknowledge keeps level, clears latch
    wr(3'd0, 32'hC000_0000);
    idle(2);
    chk("R7 ack clears", 32'(irq_level), 32'd0);
    rd(3'd0, r); chk("R7 ack read", r, 32'h4000_7000);

    // R6 falling polarity on source 1
    wr(3'd4, 32'h0600_000D);
    wr(3'd0, 32'h0A00_0000);
    src_in[1] = 1'b1; idle(6);
    chk("R6 rising ignored", 32'(irq_level), 32'd0);
    src_in[1] = 1'b0; idle(6);
    chk("R6 falling level", 32'(irq_level), 32'd2);
    chk("R6 falling src", 32'(irq_src), 32'd1);

    // R7 mask write clears latch
    wr(3'd0, 32'h0800_0000); idle(2);
    chk("R7 masked", 32'(irq_level), 32'd0);
    wr(3'd0, 32'h0A00_0000); idle(2);
    chk("R7 mask dropped edge", 32'(irq_level), 32'd0);
    rd(3'd0, r); chk("R7 read after mask", r, 32'h4200_7000);

    // R10 polarity bits and unmapped address
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, r); chk("R10 polarity ext only", r, 32'h0600_000F);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, r); chk("R10 unmapped read", r, 32'h0);
    rd(3'd0, r); chk("R10 unmapped no effect", r, 32'h4200_7000);
    src_in[21] = 1'b1; idle(2);
    chk("R10 level intact", 32'(irq_level), 32'd5);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1; idle(2);
    chk("R1 reset level", 32'(irq_level), 32'd0);
    rd(3'd0, r); chk("R1 reset word0", r, 32'h0);
    rd(3'd2, r); chk("R1 reset word2 pending only", r, 32'h0000_0800);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule